// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block holds the machine-mode control and status registers of a 32-bit RISC-V style core and sequences its traps. Each cycle the core may present one instruction at an instruction boundary (`step_valid`). If that instruction is a SYSTEM instruction (`sys_valid`), the block sees its decoded fields: funct3, the 12-bit CSR or function field, the rs1 index (which doubles as the 5-bit immediate), the rs1 value, the rd index and the current PC. The block then performs the CSR read-modify-write, an environment call (ECALL) or a trap return (MRET). For CSR instructions it returns the old CSR value for rd. For traps and returns it returns a redirect target.

A single interrupt request line carries a cause value into a one-entry pending slot. A pending interrupt is taken at the next boundary where the global machine interrupt enable is set. The taken trap replaces the presented instruction, which is not executed. The boundary still counts as one cycle of the cycle counter. Interrupts may use vectored dispatch. ECALL always goes to the direct base. EBREAK, WFI and other function codes under funct3 = 0 have no effect.

Top module: `mtcsr_unit`

## Requirements
- R1: After reset, every CSR (mstatus 0x300, mie 0x304, mtvec 0x305, mscratch 0x340, mepc 0x341, mcause 0x342, mtval 0x343), the cycle counter and the pending interrupt slot are zero, and no redirect is signalled.
- R2: A CSR instruction (funct3[1:0] != 0) returns the CSR's value from before the update on `rd_wdata`. `rd_we` is 1 only when the rd index is nonzero. The CSR update happens even when rd is x0.
- R3: funct3[1:0] = 1 writes the operand, 2 sets the operand's one bits, and 3 clears them. With funct3[2] = 1 the operand is the 5-bit rs1 field zero-extended; otherwise it is `sys_rs1_val`. For set and clear, a zero operand leaves the CSR unwritten.
- R4: A pending interrupt is taken only at a boundary (`step_valid` = 1) and only while mstatus bit 3 (MIE) is 1. The presented instruction is then not executed: no CSR change, `rd_we` = 0. `irq_take` and `redirect_valid` are both 1.
- R5: On taking an interrupt, mstatus bit 7 (MPIE) receives the old MIE, MIE becomes 0, mepc receives the current PC, and mcause receives the full cause word.
- R6: If mtvec[1:0] = 1, an interrupt redirects to {mtvec[31:2],00} + 4 × cause[4:0]. For any other mode it redirects to {mtvec[31:2],00}.
- R7: ECALL (funct3 = 0, function field 0x000) redirects to {mtvec[31:2],00} even in vectored mode. It saves MIE into MPIE, clears MIE, sets mepc to the ECALL's own PC, and sets mcause to 11.
- R8: MRET (funct3 = 0, function field 0x302) redirects to mepc. It copies MPIE into MIE and sets MPIE to 1.
- R9: The cycle counter increments once per boundary, including a boundary consumed by a trap. It reads low 32 bits at 0xB00 and 0xC00 and high bits at 0xB80 and 0xC80. Writes to these addresses are ignored.
- R10: A new interrupt request overwrites any earlier cause still pending. Taking the trap empties the slot, so re-enabling MIE afterwards takes nothing.
- R11: Other funct3 = 0 codes (EBREAK 0x001, WFI 0x105) do not redirect, write rd or change state. CSR addresses outside the set above read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | Core is at an instruction boundary this cycle |
| sys_valid | input | 1 | Presented instruction is a SYSTEM instruction |
| sys_funct3 | input | 3 | funct3 of the SYSTEM instruction |
| sys_func12 | input | 12 | CSR address or privileged function code |
| sys_rs1_idx | input | 5 | rs1 index, also the 5-bit immediate |
| sys_rs1_val | input | XLEN | Value of register rs1 |
| sys_rd_idx | input | 5 | Destination register index |
| cur_pc | input | XLEN | PC of the presented instruction |
| irq_req | input | 1 | Interrupt request strobe |
| irq_cause | input | XLEN | Cause word of the request |
| irq_take | output | 1 | Pending interrupt taken at this boundary |
| rd_we | output | 1 | Write `rd_wdata` to register rd |
| rd_idx | output | 5 | Register index for the rd write |
| rd_wdata | output | XLEN | Old CSR value |
| redirect_valid | output | 1 | Fetch must go to `redirect_pc` |
| redirect_pc | output | XLEN | Redirect target |

## Verification
The bench goes after the masked-interrupt case: a design that ignores MIE would trap before software enables interrupts. It also checks that, when an interrupt is taken, the presented instruction is squashed; a design that lets the CSR write through corrupts mscratch. ECALL under vectored mode is checked against the direct base, because a design that shares the vector logic would land at base plus 44. Pending-slot overwrite and clearing are checked too: a design that keeps the first cause reports the wrong mcause, and one that keeps the slot full takes a second spurious trap. The bench also covers zero-operand set and clear, the zero-extended immediate, writes to the read-only counter, and rd of x0.

// File: rtl/mtcsr_pkg.sv
package mtcsr_pkg;
   localparam logic [11:0] A_MSTATUS  = 12'h300;
   localparam logic [11:0] A_MIE      = 12'h304;
   localparam logic [11:0] A_MTVEC    = 12'h305;
   localparam logic [11:0] A_MSCRATCH = 12'h340;
   localparam logic [11:0] A_MEPC     = 12'h341;
   localparam logic [11:0] A_MCAUSE   = 12'h342;
   localparam logic [11:0] A_MTVAL    = 12'h343;
   localparam logic [11:0] A_CYC_LO_M = 12'hB00;
   localparam logic [11:0] A_CYC_LO_U = 12'hC00;
   localparam logic [11:0] A_CYC_HI_M = 12'hB80;
   localparam logic [11:0] A_CYC_HI_U = 12'hC80;

   localparam logic [11:0] F_ECALL = 12'h000;
   localparam logic [11:0] F_MRET  = 12'h302;

   localparam int BIT_MIE  = 3;
   localparam int BIT_MPIE = 7;
   localparam int ECALL_CAUSE = 11;

   typedef enum logic [1:0] {
      RMW_NONE  = 2'd0,
      RMW_WRITE = 2'd1,
      RMW_SET   = 2'd2,
      RMW_CLEAR = 2'd3
   } rmw_kind_e;
endpackage

// File: rtl/mtcsr_pending.sv
module mtcsr_pending #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [XLEN-1:0] req_cause,
   input  logic            consume,
   output logic            pend_valid,
   output logic [XLEN-1:0] pend_cause
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_cause <= '0;
      end else if (req) begin
         pend_valid <= 1'b1;
         pend_cause <= req_cause;
      end else if (consume) begin
         pend_valid <= 1'b0;
         pend_cause <= '0;
      end
   end
endmodule

// File: rtl/mtcsr_cycle.sv
module mtcsr_cycle #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/mtcsr_vector.sv
module mtcsr_vector #(
   parameter int XLEN   = 32,
   parameter int NUM_W  = 5,
   parameter bit VEC_EN = 1'b1
) (
   input  logic [XLEN-1:0] mtvec,
   input  logic [NUM_W-1:0] num,
   input  logic            is_irq,
   output logic [XLEN-1:0] target
);
   logic [XLEN-1:0] base;
   assign base = {mtvec[XLEN-1:2], 2'b00};

   generate
      if (VEC_EN) begin : g_vec
         logic [XLEN-1:0] offs;
         assign offs   = {{(XLEN-NUM_W-2){1'b0}}, num, 2'b00};
         assign target = (is_irq && mtvec[1:0] == 2'd1) ? base + offs : base;
      end else begin : g_direct
         assign target = base;
      end
   endgenerate
endmodule

// File: rtl/mtcsr_unit.sv
module mtcsr_unit
   import mtcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int CNT_W  = 64,
   parameter int NUM_W  = 5,
   parameter bit VEC_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_valid,
   input  logic            sys_valid,
   input  logic [2:0]      sys_funct3,
   input  logic [11:0]     sys_func12,
   input  logic [4:0]      sys_rs1_idx,
   input  logic [XLEN-1:0] sys_rs1_val,
   input  logic [4:0]      sys_rd_idx,
   input  logic [XLEN-1:0] cur_pc,
   input  logic            irq_req,
   input  logic [XLEN-1:0] irq_cause,
   output logic            irq_take,
   output logic            rd_we,
   output logic [4:0]      rd_idx,
   output logic [XLEN-1:0] rd_wdata,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc
);
   localparam int IMM_PAD = XLEN - 5;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mtcsr_unit: XLEN must be 32");
      end
      if (CNT_W <= 32 || CNT_W > 64) begin : g_bad_cnt
         $error("mtcsr_unit: CNT_W must be in 33..64");
      end
      if (NUM_W < 1 || NUM_W > XLEN - 3) begin : g_bad_num
         $error("mtcsr_unit: NUM_W out of range");
      end
   endgenerate

   logic [XLEN-1:0] mstatus_q, mie_q, mtvec_q, mscratch_q, mepc_q, mcause_q, mtval_q;
   logic            pend_valid;
   logic [XLEN-1:0] pend_cause;
   logic [CNT_W-1:0] cyc_cnt;
   logic [63:0]     cyc64;
   logic            exec_go, csr_go, ecall_go, mret_go;
   rmw_kind_e       rmw;
   logic [XLEN-1:0] operand, csr_old, csr_new, vec_pc;
   logic            csr_wr;
   logic [XLEN-1:0] st_trap, st_ret;

   mtcsr_pending #(.XLEN(XLEN)) u_pend (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .req_cause(irq_cause),
      .consume(irq_take), .pend_valid(pend_valid), .pend_cause(pend_cause)
   );

   mtcsr_cycle #(.CNT_W(CNT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .inc(step_valid), .count(cyc_cnt)
   );

   mtcsr_vector #(.XLEN(XLEN), .NUM_W(NUM_W), .VEC_EN(VEC_EN)) u_vec (
      .mtvec(mtvec_q), .num(pend_cause[NUM_W-1:0]), .is_irq(irq_take), .target(vec_pc)
   );

   assign cyc64    = 64'(cyc_cnt);
   assign irq_take = step_valid & pend_valid & mstatus_q[BIT_MIE];
   assign exec_go  = step_valid & sys_valid & ~irq_take;
   assign rmw      = rmw_kind_e'(sys_funct3[1:0]);
   assign csr_go   = exec_go & (rmw != RMW_NONE);
   assign ecall_go = exec_go & (sys_funct3 == 3'd0) & (sys_func12 == F_ECALL);
   assign mret_go  = exec_go & (sys_funct3 == 3'd0) & (sys_func12 == F_MRET);

   assign operand = sys_funct3[2] ? {{IMM_PAD{1'b0}}, sys_rs1_idx} : sys_rs1_val;

   always_comb begin
      unique case (sys_func12)
         A_MSTATUS:               csr_old = mstatus_q;
         A_MIE:                   csr_old = mie_q;
         A_MTVEC:                 csr_old = mtvec_q;
         A_MSCRATCH:              csr_old = mscratch_q;
         A_MEPC:                  csr_old = mepc_q;
         A_MCAUSE:                csr_old = mcause_q;
         A_MTVAL:                 csr_old = mtval_q;
         A_CYC_LO_M, A_CYC_LO_U:  csr_old = cyc64[31:0];
         A_CYC_HI_M, A_CYC_HI_U:  csr_old = cyc64[63:32];
         default:                 csr_old = '0;
      endcase
   end

   always_comb begin
      csr_new = csr_old;
      csr_wr  = 1'b0;
      case (rmw)
         RMW_WRITE: begin csr_new = operand;            csr_wr = 1'b1;            end
         RMW_SET:   begin csr_new = csr_old | operand;  csr_wr = (operand != '0); end
         RMW_CLEAR: begin csr_new = csr_old & ~operand; csr_wr = (operand != '0); end
         default:   begin csr_new = csr_old;            csr_wr = 1'b0;            end
      endcase
   end

   always_comb begin
      st_trap = mstatus_q;
      st_trap[BIT_MPIE] = mstatus_q[BIT_MIE];
      st_trap[BIT_MIE]  = 1'b0;
      st_ret = mstatus_q;
      st_ret[BIT_MIE]  = mstatus_q[BIT_MPIE];
      st_ret[BIT_MPIE] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mstatus_q  <= '0;
         mie_q      <= '0;
         mtvec_q    <= '0;
         mscratch_q <= '0;
         mepc_q     <= '0;
         mcause_q   <= '0;
         mtval_q    <= '0;
      end else if (irq_take) begin
         mstatus_q <= st_trap;
         mepc_q    <= cur_pc;
         mcause_q  <= pend_cause;
      end else if (ecall_go) begin
         mstatus_q <= st_trap;
         mepc_q    <= cur_pc;
         mcause_q  <= XLEN'(ECALL_CAUSE);
      end else if (mret_go) begin
         mstatus_q <= st_ret;
      end else if (csr_go && csr_wr) begin
         case (sys_func12)
            A_MSTATUS:  mstatus_q  <= csr_new;
            A_MIE:      mie_q      <= csr_new;
            A_MTVEC:    mtvec_q    <= csr_new;
            A_MSCRATCH: mscratch_q <= csr_new;
            A_MEPC:     mepc_q     <= csr_new;
            A_MCAUSE:   mcause_q   <= csr_new;
            A_MTVAL:    mtval_q    <= csr_new;
            default: ;
         endcase
      end
   end

   assign rd_we          = csr_go & (sys_rd_idx != 5'd0);
   assign rd_idx         = sys_rd_idx;
   assign rd_wdata       = csr_old;
   assign redirect_valid = irq_take | ecall_go | mret_go;
   assign redirect_pc    = mret_go ? mepc_q : vec_pc;
endmodule

// File: rtl/mtcsr_checker.sv
module mtcsr_checker #(
   parameter int XLEN  = 32,
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_valid,
   input logic             irq_take,
   input logic             ecall_go,
   input logic             mret_go,
   input logic             rd_we,
   input logic [4:0]       rd_idx,
   input logic [XLEN-1:0]  redirect_pc,
   input logic [XLEN-1:0]  cur_pc,
   input logic [XLEN-1:0]  mstatus_q,
   input logic [XLEN-1:0]  mepc_q,
   input logic [XLEN-1:0]  mcause_q,
   input logic [CNT_W-1:0] cyc_cnt
);
   AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (step_valid && mstatus_q[3])); // R4
   AST_ONE_REDIRECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_take, ecall_go, mret_go})); // R4
   AST_TRAP_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> (!mstatus_q[3] && mstatus_q[7] && mepc_q == $past(cur_pc))); // R5
   AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ecall_go |=> (mcause_q == XLEN'(11) && mepc_q == $past(cur_pc) && !mstatus_q[3])); // R7
   AST_MRET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      mret_go |-> redirect_pc == mepc_q); // R8
   AST_MRET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      mret_go |=> (mstatus_q[7] && mstatus_q[3] == $past(mstatus_q[7]))); // R8
   AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |=> cyc_cnt == $past(cyc_cnt) + 1'b1); // R9
   AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step_valid |=> $stable(cyc_cnt)); // R9
   AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> rd_idx != 5'd0); // R2
endmodule

bind mtcsr_unit mtcsr_checker #(.XLEN(XLEN), .CNT_W(CNT_W)) u_mtcsr_chk (
   .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .irq_take(irq_take),
   .ecall_go(ecall_go), .mret_go(mret_go), .rd_we(rd_we), .rd_idx(rd_idx),
   .redirect_pc(redirect_pc), .cur_pc(cur_pc), .mstatus_q(mstatus_q),
   .mepc_q(mepc_q), .mcause_q(mcause_q), .cyc_cnt(cyc_cnt)
);

// File: tb/test_mtcsr_unit.sv
`timescale 1ns/1ps
module test_mtcsr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_valid = 1'b0, sys_valid = 1'b0;
   logic [2:0]  sys_funct3 = '0;
   logic [11:0] sys_func12 = '0;
   logic [4:0]  sys_rs1_idx = '0, sys_rd_idx = '0;
   logic [31:0] sys_rs1_val = '0, cur_pc = '0;
   logic        irq_req = 1'b0;
   logic [31:0] irq_cause = '0;
   logic        irq_take, rd_we, redirect_valid;
   logic [4:0]  rd_idx;
   logic [31:0] rd_wdata, redirect_pc;

   int      n_tests = 0, n_fail = 0;
   longint  exp_cyc = 0;
   logic        c_take, c_we, c_redir;
   logic [31:0] c_data, c_pc;

   always #2.5 clk = ~clk;

   mtcsr_unit i_mtcsr_unit (
      .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .sys_valid(sys_valid),
      .sys_funct3(sys_funct3), .sys_func12(sys_func12), .sys_rs1_idx(sys_rs1_idx),
      .sys_rs1_val(sys_rs1_val), .sys_rd_idx(sys_rd_idx), .cur_pc(cur_pc),
      .irq_req(irq_req), .irq_cause(irq_cause), .irq_take(irq_take), .rd_we(rd_we),
      .rd_idx(rd_idx), .rd_wdata(rd_wdata), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // One boundary; starts and ends at a falling edge.
   task automatic do_step(input bit sys, input logic [2:0] f3, input logic [11:0] f12,
                          input logic [4:0] ri, input logic [31:0] rv,
                          input logic [4:0] rd, input logic [31:0] pc);
      step_valid = 1'b1; sys_valid = sys; sys_funct3 = f3; sys_func12 = f12;
      sys_rs1_idx = ri; sys_rs1_val = rv; sys_rd_idx = rd; cur_pc = pc;
      #1;
      c_take = irq_take; c_we = rd_we; c_redir = redirect_valid;
      c_data = rd_wdata; c_pc = redirect_pc;
      @(posedge clk);
      exp_cyc++;
      @(negedge clk);
      step_valid = 1'b0; sys_valid = 1'b0;
   endtask

   task automatic rd_csr(input logic [11:0] a, output logic [31:0] v);
      do_step(1'b1, 3'd2, a, 5'd0, 32'h0, 5'd1, 32'h0);
      v = c_data;
   endtask

   task automatic pulse_irq(input logic [31:0] cause);
      irq_req = 1'b1; irq_cause = cause;
      @(negedge clk);
      irq_req = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 redirect after reset", {31'd0, redirect_valid}, 32'd0);
      rd_csr(12'h300, v); check("R1 mstatus", v, 0);
      rd_csr(12'h304, v); check("R1 mie", v, 0);
      rd_csr(12'h305, v); check("R1 mtvec", v, 0);
      rd_csr(12'h340, v); check("R1 mscratch", v, 0);
      rd_csr(12'h341, v); check("R1 mepc", v, 0);
      rd_csr(12'h342, v); check("R1 mcause", v, 0);
      rd_csr(12'h343, v); check("R1 mtval", v, 0);
      rd_csr(12'hC00, v); check("R1 cycle", v, 32'd7);
      check("R1 no redirect on reads", {31'd0, c_redir}, 0);
   endtask

   task automatic t_csr_rmw();
      logic [31:0] v;
      do_step(1'b1, 3'd1, 12'h340, 5'd3, 32'hA5A5_1234, 5'd1, 32'h10);
      check("R2 old value", c_data, 0);
      check("R2 rd_we", {31'd0, c_we}, 1);
      do_step(1'b1, 3'd1, 12'h340, 5'd3, 32'h0000_0011, 5'd0, 32'h14);
      check("R2 rd x0 no write", {31'd0, c_we}, 0);
      check("R2 old value rd x0", c_data, 32'hA5A5_1234);
      rd_csr(12'h340, v); check("R2 update with rd x0", v, 32'h11);
      do_step(1'b1, 3'd2, 12'h340, 5'd3, 32'h0000_0F00, 5'd2, 32'h18);
      rd_csr(12'h340, v); check("R3 set", v, 32'hF11);
      do_step(1'b1, 3'd3, 12'h340, 5'd3, 32'h0000_0011, 5'd2, 32'h1C);
      rd_csr(12'h340, v); check("R3 clear", v, 32'hF00);
      do_step(1'b1, 3'd6, 12'h343, 5'h1F, 32'hFFFF_FFFF, 5'd2, 32'h20);
      rd_csr(12'h343, v); check("R3 set imm zext", v, 32'h1F);
      do_step(1'b1, 3'd7, 12'h343, 5'h03, 32'hFFFF_FFFF, 5'd2, 32'h24);
      rd_csr(12'h343, v); check("R3 clear imm", v, 32'h1C);
      do_step(1'b1, 3'd5, 12'h304, 5'h15, 32'hFFFF_FFFF, 5'd2, 32'h28);
      rd_csr(12'h304, v); check("R3 write imm", v, 32'h15);
      do_step(1'b1, 3'd7, 12'h304, 5'h00, 32'hFFFF_FFFF, 5'd2, 32'h2C);
      check("R3 zero clear returns old", c_data, 32'h15);
      rd_csr(12'h304, v); check("R3 zero clear skipped", v, 32'h15);
   endtask

   task automatic t_ro_and_noop();
      logic [31:0] v;
      longint e;
      e = exp_cyc;
      do_step(1'b1, 3'd1, 12'hB00, 5'd3, 32'hFFFF_FFFF, 5'd1, 32'h30);
      check("R9 cycle old value", c_data, 32'(e));
      e = exp_cyc;
      rd_csr(12'hB00, v); check("R9 cycle write ignored", v, 32'(e));
      rd_csr(12'hC80, v); check("R9 cycle high", v, 0);
      rd_csr(12'hB80, v); check("R9 mcycle high", v, 0);
      do_step(1'b1, 3'd1, 12'h7C0, 5'd3, 32'h1234, 5'd1, 32'h34);
      check("R11 unknown csr reads zero", c_data, 0);
      rd_csr(12'h7C0, v); check("R11 unknown csr ignores write", v, 0);
      do_step(1'b1, 3'd0, 12'h001, 5'd0, 32'h0, 5'd1, 32'h38);
      check("R11 ebreak no redirect", {31'd0, c_redir}, 0);
      check("R11 ebreak no rd", {31'd0, c_we}, 0);
      do_step(1'b1, 3'd0, 12'h105, 5'd0, 32'h0, 5'd1, 32'h3C);
      check("R11 wfi no redirect", {31'd0, c_redir}, 0);
      rd_csr(12'h300, v); check("R11 mstatus untouched", v, 0);
      rd_csr(12'h341, v); check("R11 mepc untouched", v, 0);
   endtask

   task automatic t_irq_vectored();
      logic [31:0] v;
      do_step(1'b1, 3'd1, 12'h305, 5'd3, 32'h0000_1001, 5'd0, 32'h40);
      pulse_irq(32'h8000_0003);
      pulse_irq(32'h8000_0005);
      do_step(1'b0, 3'd0, 12'h0, 5'd0, 32'h0, 5'd0, 32'h44);
      check("R4 masked no take", {31'd0, c_take}, 0);
      check("R4 masked no redirect", {31'd0, c_redir}, 0);
      do_step(1'b1, 3'd6, 12'h300, 5'd8, 32'h0, 5'd0, 32'h100);
      check("R4 enabling step not trapped", {31'd0, c_take}, 0);
      do_step(1'b1, 3'd1, 12'h340, 5'd3, 32'h0000_DEAD, 5'd2, 32'h200);
      check("R4 take", {31'd0, c_take}, 1);
      check("R4 redirect", {31'd0, c_redir}, 1);
      check("R4 squashed rd", {31'd0, c_we}, 0);
      check("R6 vectored target", c_pc, 32'h1014);
      rd_csr(12'h340, v); check("R4 squashed csr write", v, 32'hF00);
      rd_csr(12'h341, v); check("R5 mepc", v, 32'h200);
      rd_csr(12'h342, v); check("R10 newest cause kept", v, 32'h8000_0005);
      rd_csr(12'h300, v); check("R5 mstatus after trap", v, 32'h80);
      do_step(1'b1, 3'd6, 12'h300, 5'd8, 32'h0, 5'd0, 32'h204);
      do_step(1'b0, 3'd0, 12'h0, 5'd0, 32'h0, 5'd0, 32'h208);
      check("R10 slot cleared", {31'd0, c_take}, 0);
   endtask

   task automatic t_mret_ecall();
      logic [31:0] v;
      do_step(1'b1, 3'd1, 12'h300, 5'd3, 32'h0000_0080, 5'd0, 32'h2FC);
      do_step(1'b1, 3'd0, 12'h302, 5'd0, 32'h0, 5'd0, 32'h300);
      check("R8 mret redirect", {31'd0, c_redir}, 1);
      check("R8 mret target", c_pc, 32'h200);
      rd_csr(12'h300, v); check("R8 mstatus after mret", v, 32'h88);
      do_step(1'b1, 3'd0, 12'h000, 5'd0, 32'h0, 5'd0, 32'h400);
      check("R7 ecall redirect", {31'd0, c_redir}, 1);
      check("R7 ecall direct base", c_pc, 32'h1000);
      check("R7 ecall not an irq", {31'd0, c_take}, 0);
      rd_csr(12'h341, v); check("R7 mepc", v, 32'h400);
      rd_csr(12'h342, v); check("R7 mcause", v, 32'd11);
      rd_csr(12'h300, v); check("R7 mstatus", v, 32'h80);
   endtask

   task automatic t_irq_direct();
      logic [31:0] v;
      longint e;
      do_step(1'b1, 3'd1, 12'h305, 5'd3, 32'h0000_2002, 5'd0, 32'h500);
      do_step(1'b1, 3'd6, 12'h300, 5'd8, 32'h0, 5'd0, 32'h504);
      pulse_irq(32'h8000_0007);
      e = exp_cyc;
      do_step(1'b0, 3'd0, 12'h0, 5'd0, 32'h0, 5'd0, 32'h508);
      check("R4 take direct", {31'd0, c_take}, 1);
      check("R6 direct target", c_pc, 32'h2000);
      rd_csr(12'h342, v); check("R5 mcause direct", v, 32'h8000_0007);
      rd_csr(12'hC00, v); check("R9 trap counts a cycle", v, 32'(e + 2));
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_csr_rmw();
      t_ro_and_noop();
      t_irq_vectored();
      t_mret_ecall();
      t_irq_direct();
      finish_run();
   end
endmodule